// File: doc/BRIEF.md
# Per-Pad Peripheral Signal Router

This block connects a set of bidirectional tri-state pads to a larger pool of peripheral signal slots. Each slot has a write value, a write-enable value and a read return. Each pad holds a small list of candidate slots, fixed when the design is elaborated, and a selector input chooses one entry from that list. The chosen slot's write and write-enable drive the pad. The pad's read value goes back to that slot only.

The candidate lists are sparse and set per pad. A slot may appear in the lists of several pads. The slot pool can be larger or smaller than pads times options. Selectors are plain 8-bit inputs; the block reads only their low bits. The whole path is combinational. The selectors normally come from configuration registers outside this block.

A selector that points past the end of its pad's list parks the pad in a safe driven-low state. A slot that no pad currently selects sees a read value of 0.

Top module: `pin_signal_mux`

## Requirements
- R1: For pad p with selector index N below that pad's list length, `pad_wr[p]` equals `slot_wr[CAND[p][N]]` and `pad_oe[p]` equals `slot_oe[CAND[p][N]]`. The default lists are: pad0 {0,1,2,3}, pad1 {2,4}, pad2 {5,0,3}, pad3 {1}.
- R2: When pad p selects slot s, `slot_rd[s]` is 1 whenever `pad_rd[p]` is 1.
- R3: A slot that no pad currently selects reads 0 on `slot_rd`, whatever the pad read values are.
- R4: When a pad's selector index is equal to or greater than its list length, the pad drives low: `pad_wr` is 0 and `pad_oe` is 1. No slot is connected to that pad.
- R5: Only the low SELW = ceil(log2(NOPTS)) bits of each 8-bit selector are used (bits [1:0] by default). The upper bits have no effect.
- R6: Several pads may select the same slot at once. Each of them then drives that slot's write and write-enable, and the slot's read value is the OR of their pad read values.
- R7: With every selector at 0, each pad connects to the first entry of its list.
- R8: Each pad connects to at most one slot at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pad_sel | input | NPADS x 8 | Per-pad selector value; only the low SELW bits are used |
| slot_wr | input | NSLOTS | Write value offered by each peripheral slot |
| slot_oe | input | NSLOTS | Write-enable offered by each peripheral slot |
| slot_rd | output | NSLOTS | Read value returned to each peripheral slot |
| pad_wr | output | NPADS | Write value driven toward each pad |
| pad_oe | output | NPADS | Output enable driven toward each pad |
| pad_rd | input | NPADS | Read value sampled from each pad |

## Verification
The block has no stored state, so any decode error shows at the ports in the same evaluation in which the selectors or signals change. A wrong candidate index sends another slot's write value to the pad, and a stale or extra one-hot bit leaks a pad read into a slot that no pad selected. A broken range check shows up as a pad that floats, or that copies a slot, where it should drive low. Each pad is swept through every selector value under several slot and read patterns. These patterns include pads that share a slot and selectors with the upper bits set, so each of these errors is visible in the first compare after the change.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int unsigned SEL_REG_W = 8;

  function automatic int unsigned sel_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pmx_pad_decode.sv
module pmx_pad_decode #(
  parameter int unsigned NPADS  = 4,
  parameter int unsigned NSLOTS = 6,
  parameter int unsigned NOPTS  = 4,
  parameter int unsigned PAD    = 0,
  parameter int CAND [NPADS][NOPTS] = '{'{0,1,2,3},'{2,4,0,0},'{5,0,3,0},'{1,0,0,0}},
  parameter int CAND_LEN [NPADS]    = '{4,2,3,1}
) (
  input  logic [pmx_pkg::SEL_REG_W-1:0] sel,
  output logic [NSLOTS-1:0]             hit,
  output logic                          in_range
);
  localparam int unsigned SELW = pmx_pkg::sel_bits(NOPTS);

  logic [SELW-1:0] idx;
  assign idx = sel[SELW-1:0];

  always_comb begin
    hit      = '0;
    in_range = 1'b0;
    for (int k = 0; k < NOPTS; k++) begin
      if (k < CAND_LEN[PAD] && CAND[PAD][k] >= 0 && CAND[PAD][k] < NSLOTS
          && idx == SELW'(k)) begin
        hit[CAND[PAD][k]] = 1'b1;
        in_range          = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pmx_pad_drive.sv
module pmx_pad_drive #(
  parameter int unsigned NSLOTS = 6
) (
  input  logic [NSLOTS-1:0] hit,
  input  logic              in_range,
  input  logic [NSLOTS-1:0] slot_wr,
  input  logic [NSLOTS-1:0] slot_oe,
  output logic              wr,
  output logic              oe
);
  always_comb begin
    if (in_range) begin
      wr = |(hit & slot_wr);
      oe = |(hit & slot_oe);
    end else begin
      wr = 1'b0;
      oe = 1'b1;
    end
  end
endmodule

// File: rtl/pmx_rd_merge.sv
module pmx_rd_merge #(
  parameter int unsigned NPADS  = 4,
  parameter int unsigned NSLOTS = 6
) (
  input  logic [NPADS-1:0][NSLOTS-1:0] hit,
  input  logic [NPADS-1:0]             pad_rd,
  output logic [NSLOTS-1:0]            slot_rd
);
  always_comb begin
    slot_rd = '0;
    for (int p = 0; p < NPADS; p++) begin
      slot_rd = slot_rd | (hit[p] & {NSLOTS{pad_rd[p]}});
    end
  end
endmodule

// File: rtl/pin_signal_mux.sv
module pin_signal_mux #(
  parameter int unsigned NPADS  = 4,
  parameter int unsigned NSLOTS = 6,
  parameter int unsigned NOPTS  = 4,
  parameter int CAND [NPADS][NOPTS] = '{'{0,1,2,3},'{2,4,0,0},'{5,0,3,0},'{1,0,0,0}},
  parameter int CAND_LEN [NPADS]    = '{4,2,3,1}
) (
  input  logic [NPADS-1:0][pmx_pkg::SEL_REG_W-1:0] pad_sel,
  input  logic [NSLOTS-1:0]                        slot_wr,
  input  logic [NSLOTS-1:0]                        slot_oe,
  output logic [NSLOTS-1:0]                        slot_rd,
  output logic [NPADS-1:0]                         pad_wr,
  output logic [NPADS-1:0]                         pad_oe,
  input  logic [NPADS-1:0]                         pad_rd
);
  logic [NPADS-1:0][NSLOTS-1:0] pad_hit;
  logic [NPADS-1:0]             pad_ok;

  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    pmx_pad_decode #(
      .NPADS(NPADS), .NSLOTS(NSLOTS), .NOPTS(NOPTS), .PAD(p),
      .CAND(CAND), .CAND_LEN(CAND_LEN)
    ) u_dec (
      .sel      (pad_sel[p]),
      .hit      (pad_hit[p]),
      .in_range (pad_ok[p])
    );

    pmx_pad_drive #(.NSLOTS(NSLOTS)) u_drv (
      .hit      (pad_hit[p]),
      .in_range (pad_ok[p]),
      .slot_wr  (slot_wr),
      .slot_oe  (slot_oe),
      .wr       (pad_wr[p]),
      .oe       (pad_oe[p])
    );
  end

  pmx_rd_merge #(.NPADS(NPADS), .NSLOTS(NSLOTS)) u_rd (
    .hit     (pad_hit),
    .pad_rd  (pad_rd),
    .slot_rd (slot_rd)
  );
endmodule

// File: rtl/pmx_checker.sv
module pmx_checker #(
  parameter int unsigned NPADS  = 4,
  parameter int unsigned NSLOTS = 6,
  parameter int unsigned NOPTS  = 4,
  parameter int CAND_LEN [NPADS] = '{4,2,3,1}
) (
  input logic [NPADS-1:0][pmx_pkg::SEL_REG_W-1:0] pad_sel,
  input logic [NSLOTS-1:0]                        slot_wr,
  input logic [NSLOTS-1:0]                        slot_oe,
  input logic [NSLOTS-1:0]                        slot_rd,
  input logic [NPADS-1:0]                         pad_wr,
  input logic [NPADS-1:0]                         pad_oe,
  input logic [NPADS-1:0]                         pad_rd,
  input logic [NPADS-1:0][NSLOTS-1:0]             pad_hit
);
  localparam int unsigned SELW = pmx_pkg::sel_bits(NOPTS);

  always_comb begin
    for (int p = 0; p < NPADS; p++) begin
      AST_ONE_SLOT: assert ($countones(pad_hit[p]) <= 1); // R8
      if (32'(pad_sel[p][SELW-1:0]) >= CAND_LEN[p]) begin
        AST_PARK_LOW: assert (pad_oe[p] && !pad_wr[p] && pad_hit[p] == '0); // R4
      end
      for (int s = 0; s < NSLOTS; s++) begin
        if (pad_hit[p][s]) begin
          AST_FWD_SLOT: assert (pad_wr[p] == slot_wr[s] && pad_oe[p] == slot_oe[s]); // R1
          if (pad_rd[p]) begin
            AST_RD_RETURN: assert (slot_rd[s]); // R2
          end
        end
      end
    end
    for (int s = 0; s < NSLOTS; s++) begin
      if (slot_rd[s]) begin
        AST_RD_SOURCED: assert (|pad_rd); // R3
      end
    end
  end
endmodule

bind pin_signal_mux pmx_checker #(
  .NPADS(NPADS), .NSLOTS(NSLOTS), .NOPTS(NOPTS), .CAND_LEN(CAND_LEN)
) u_chk (
  .pad_sel (pad_sel),
  .slot_wr (slot_wr),
  .slot_oe (slot_oe),
  .slot_rd (slot_rd),
  .pad_wr  (pad_wr),
  .pad_oe  (pad_oe),
  .pad_rd  (pad_rd),
  .pad_hit (pad_hit)
);

// File: tb/tb_pin_signal_mux.sv
module tb_pin_signal_mux;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NS = 6;
  localparam int MAPT [NP][4] = '{'{0,1,2,3},'{2,4,0,0},'{5,0,3,0},'{1,0,0,0}};
  localparam int LENT [NP]    = '{4,2,3,1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NP-1:0][7:0] pad_sel;
  logic [NS-1:0] slot_wr, slot_oe, slot_rd;
  logic [NP-1:0] pad_wr, pad_oe, pad_rd;

  pin_signal_mux dut (
    .pad_sel(pad_sel), .slot_wr(slot_wr), .slot_oe(slot_oe), .slot_rd(slot_rd),
    .pad_wr(pad_wr), .pad_oe(pad_oe), .pad_rd(pad_rd)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [NP-1:0] e_wr, e_oe;
  logic [NS-1:0] e_rd;

  function automatic void model();
    e_wr = '0; e_oe = '0; e_rd = '0;
    for (int p = 0; p < NP; p++) begin
      int idx;
      idx = int'(pad_sel[p][1:0]);
      if (idx < LENT[p]) begin
        e_wr[p] = slot_wr[MAPT[p][idx]];
        e_oe[p] = slot_oe[MAPT[p][idx]];
        if (pad_rd[p]) e_rd[MAPT[p][idx]] = 1'b1;
      end else begin
        e_wr[p] = 1'b0;
        e_oe[p] = 1'b1;
      end
    end
  endfunction

  task automatic compare(input string req);
    model();
    @(negedge clk);
    n_cmp++;
    if (pad_wr !== e_wr || pad_oe !== e_oe || slot_rd !== e_rd) begin
      n_bad++;
      $display("FAIL %s sel=%h: wr=%b/%b oe=%b/%b rd=%b/%b (actual/expected)",
               req, pad_sel, pad_wr, e_wr, pad_oe, e_oe, slot_rd, e_rd);
    end
  endtask

  task automatic drive(input logic [NP-1:0][7:0] s, input logic [NS-1:0] w,
                       input logic [NS-1:0] o, input logic [NP-1:0] r);
    @(posedge clk);
    pad_sel = s; slot_wr = w; slot_oe = o; pad_rd = r;
  endtask

  task automatic t_all_zero();
    drive('0, 6'b101010, 6'b010101, 4'b1111);
    compare("R7 reset-value selectors");
    drive('0, 6'b010101, 6'b101010, 4'b0101);
    compare("R7 reset-value selectors alt");
  endtask

  task automatic t_sweep();
    for (int p = 0; p < NP; p++) begin
      for (int v = 0; v < 4; v++) begin
        for (int k = 0; k < 3; k++) begin
          logic [NP-1:0][7:0] s;
          s = '0;
          s[p] = 8'(v);
          drive(s, 6'(k*13 + v*7 + 5), 6'(k*23 + p*11 + 3), 4'(k*5 + v + 1));
          compare((v >= LENT[p]) ? "R4 out-of-range" : "R1 R2 R3 selected slot");
        end
      end
    end
  endtask

  task automatic t_high_bits();
    drive({8'hFD, 8'hF6, 8'h81, 8'hC3}, 6'b110011, 6'b011110, 4'b1011);
    compare("R5 upper selector bits ignored");
    drive({8'h04, 8'h08, 8'hFC, 8'h7E}, 6'b001101, 6'b100110, 4'b1110);
    compare("R5 upper selector bits ignored b");
  endtask

  task automatic t_shared();
    // pad0 opt2 -> slot2, pad1 opt0 -> slot2; pad2 opt1 -> slot0
    drive({8'd0, 8'd1, 8'd0, 8'd2}, 6'b000100, 6'b000100, 4'b0010);
    compare("R6 shared slot read OR");
    drive({8'd0, 8'd1, 8'd0, 8'd2}, 6'b000000, 6'b000100, 4'b0001);
    compare("R6 shared slot read OR other pad");
    drive({8'd0, 8'd1, 8'd0, 8'd2}, 6'b000101, 6'b000001, 4'b0000);
    compare("R3 R6 shared slot no reads");
    drive({8'd0, 8'd0, 8'd0, 8'd1}, 6'b111111, 6'b111111, 4'b1111);
    compare("R6 R8 pad0 and pad3 on slot1");
  endtask

  task automatic t_exhaustive();
    for (int c = 0; c < 256; c++) begin
      drive({8'(c >> 6), 8'((c >> 4) & 3), 8'((c >> 2) & 3), 8'(c & 3)},
            6'(c * 37 + 11), 6'(c * 53 + 29), 4'(c * 7 + 3));
      compare("R1 R4 R8 all selector combinations");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not complete (actual hung / expected done)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    pad_sel = '0; slot_wr = '0; slot_oe = '0; pad_rd = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_all_zero();
    t_sweep();
    t_high_bits();
    t_shared();
    t_exhaustive();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule